// File: doc/BRIEF.md
# Automatic packet request counter

This block holds the endpoint-level flags that let a USB host controller pull a bulk or interrupt IN transfer through a receive endpoint without software stepping in for each packet. When automatic requesting is on, each completed packet re-arms the request flag so the next IN transaction goes out at once. A remaining-packet counter, loaded by software, stops the run after a set number of packets. A count of zero means the transfer length is unknown. The run then ends only when a packet shorter than the maximum packet size arrives.

On the transmit side, the same block raises the transmit-ready flag by itself once the FIFO holds a full maximum-sized packet, provided automatic setting is enabled. Without that mode, software sets the flag explicitly for every packet it loads. The flag drops once the packet has been sent and acknowledged. Bus signalling, FIFO storage and DMA sit outside the block. Only the byte count of the FIFO and the per-packet strobes come in.

Top module: `auto_pkt_req`

## Requirements
- R1: When autoReq is 1 and a completed packet (rxDone) does not end the transfer, reqPkt is 1 on the following cycle. When autoReq is 0, a completed packet clears reqPkt unless reqPktSet is also high.
- R2: On each rxDone, a non-zero remaining count decrements by one. The packet that takes the count from 1 to 0 clears autoReq and does not re-arm reqPkt.
- R3: With a remaining count of zero, packets of length greater than or equal to maxPkt leave autoReq set and re-arm reqPkt indefinitely.
- R4: A short packet ends the transfer. A packet is short when rxLen < maxPkt, strictly, and a zero-length packet counts as short. On a short packet, autoReq clears, reqPkt is not re-armed, and the remaining count is forced to zero whatever its value.
- R5: With autoSetEn high and maxPkt non-zero, txRdy is 1 on the cycle after fifoCount >= maxPkt. With maxPkt equal to zero, the automatic path never sets txRdy.
- R6: With autoSetEn low, txRdy rises only through txRdySet, whatever fifoCount holds.
- R7: txAck clears txRdy on the next cycle. A set (explicit or automatic) in the same cycle takes priority and keeps txRdy at 1.
- R8: Software strobes act on the next cycle. countWe loads countIn into the remaining count. autoReqWe writes autoReqVal into autoReq. reqPktSet sets reqPkt. A transfer-ending packet in the same cycle as autoReqWe wins, leaving autoReq at 0.
- R9: While rstN is low, reqPkt, autoReq and txRdy are 0 and the remaining count is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| countWe | input | 1 | Load strobe for the remaining packet count |
| countIn | input | CNT_W | Packet count value to load (0 = unknown length) |
| autoReqWe | input | 1 | Write strobe for the auto-request enable |
| autoReqVal | input | 1 | Value written to the auto-request enable |
| reqPktSet | input | 1 | Software request to issue an IN transaction |
| maxPkt | input | SIZE_W | Maximum packet size in bytes |
| rxDone | input | 1 | One-cycle strobe: an IN packet has been received |
| rxLen | input | SIZE_W | Byte length of the packet flagged by rxDone |
| autoSetEn | input | 1 | Enables automatic transmit-ready on a full FIFO |
| txRdySet | input | 1 | Explicit software set of transmit-ready |
| fifoCount | input | FILL_W | Bytes currently held in the transmit FIFO |
| txAck | input | 1 | One-cycle strobe: transmitted packet acknowledged |
| reqPkt | output | 1 | Request-packet flag (issue the next IN) |
| autoReq | output | 1 | Current auto-request enable |
| txRdy | output | 1 | Transmit-ready flag |

## Verification
The hardest case to reach from the ports is a short packet that arrives while the remaining count is still non-zero. Afterwards the count must read zero, and the internal count never leaves the block. The stimulus loads a count of five and ends the run with a 63-byte packet. It then re-arms without reloading and sends four full packets. A count left at four instead of zero would drop autoReq on the fourth packet, so the test can see the wrong value through autoReq and reqPkt alone. Strict less-than is probed at the boundary with lengths equal to maxPkt and one below it, at two different maxPkt values.

// File: rtl/apr_pkg.sv
package apr_pkg;

  // strobes from control to the count datapath
  typedef struct packed {
    logic loadCount;
    logic clearCount;
    logic decCount;
  } dpStrobes_t;

  // conditions reported back by the datapath
  typedef struct packed {
    logic isShort;
    logic countIsZero;
    logic countIsOne;
    logic fifoFull;
  } dpStatus_t;

endpackage

// File: rtl/apr_datapath.sv
module apr_datapath
  import apr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SIZE_W = 11,
  parameter int FILL_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobe,
  input  logic [CNT_W-1:0]  countIn,
  input  logic [SIZE_W-1:0] rxLen,
  input  logic [SIZE_W-1:0] maxPkt,
  input  logic [FILL_W-1:0] fifoCount,
  output logic [CNT_W-1:0]  remCount,
  output dpStatus_t         status
);

  localparam int CMP_W = (FILL_W > SIZE_W) ? FILL_W : SIZE_W;

  logic [CMP_W-1:0] fillExt;
  logic [CMP_W-1:0] maxExt;

  assign fillExt = CMP_W'(fifoCount);
  assign maxExt  = CMP_W'(maxPkt);

  // remaining packet count: software load beats hardware updates
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remCount <= '0;
    end else if (strobe.loadCount) begin
      remCount <= countIn;
    end else if (strobe.clearCount) begin
      remCount <= '0;
    end else if (strobe.decCount) begin
      remCount <= remCount - CNT_W'(1);
    end
  end

  always_comb begin
    status.isShort     = (rxLen < maxPkt);
    status.countIsZero = (remCount == '0);
    status.countIsOne  = (remCount == CNT_W'(1));
    status.fifoFull    = (maxPkt != '0) && (fillExt >= maxExt);
  end

endmodule

// File: rtl/apr_control.sv
module apr_control
  import apr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       countWe,
  input  logic       autoReqWe,
  input  logic       autoReqVal,
  input  logic       reqPktSet,
  input  logic       rxDone,
  input  logic       autoSetEn,
  input  logic       txRdySet,
  input  logic       txAck,
  input  dpStatus_t  status,
  output dpStrobes_t strobe,
  output logic       reqPkt,
  output logic       autoReq,
  output logic       txRdy
);

  logic endXfer;
  logic rearm;
  logic clrAuto;
  logic txSetAny;

  always_comb begin
    endXfer  = status.isShort || status.countIsOne;
    clrAuto  = rxDone && endXfer;
    rearm    = rxDone && autoReq && !endXfer;
    txSetAny = txRdySet || (autoSetEn && status.fifoFull);

    strobe.loadCount  = countWe;
    strobe.clearCount = rxDone && status.isShort;
    strobe.decCount   = rxDone && !status.isShort && !status.countIsZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoReq <= 1'b0;
      reqPkt  <= 1'b0;
      txRdy   <= 1'b0;
    end else begin
      if (clrAuto) begin
        autoReq <= 1'b0;
      end else if (autoReqWe) begin
        autoReq <= autoReqVal;
      end

      if (reqPktSet) begin
        reqPkt <= 1'b1;
      end else if (rxDone) begin
        reqPkt <= rearm;
      end

      if (txSetAny) begin
        txRdy <= 1'b1;
      end else if (txAck) begin
        txRdy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/auto_pkt_req.sv
module auto_pkt_req
  import apr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SIZE_W = 11,
  parameter int FILL_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              countWe,
  input  logic [CNT_W-1:0]  countIn,
  input  logic              autoReqWe,
  input  logic              autoReqVal,
  input  logic              reqPktSet,
  input  logic [SIZE_W-1:0] maxPkt,
  input  logic              rxDone,
  input  logic [SIZE_W-1:0] rxLen,
  input  logic              autoSetEn,
  input  logic              txRdySet,
  input  logic [FILL_W-1:0] fifoCount,
  input  logic              txAck,
  output logic              reqPkt,
  output logic              autoReq,
  output logic              txRdy
);

  dpStrobes_t       strobe;
  dpStatus_t        status;
  logic [CNT_W-1:0] remCount;

  apr_datapath #(
    .CNT_W (CNT_W),
    .SIZE_W(SIZE_W),
    .FILL_W(FILL_W)
  ) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .countIn  (countIn),
    .rxLen    (rxLen),
    .maxPkt   (maxPkt),
    .fifoCount(fifoCount),
    .remCount (remCount),
    .status   (status)
  );

  apr_control uControl (
    .clk       (clk),
    .rstN      (rstN),
    .countWe   (countWe),
    .autoReqWe (autoReqWe),
    .autoReqVal(autoReqVal),
    .reqPktSet (reqPktSet),
    .rxDone    (rxDone),
    .autoSetEn (autoSetEn),
    .txRdySet  (txRdySet),
    .txAck     (txAck),
    .status    (status),
    .strobe    (strobe),
    .reqPkt    (reqPkt),
    .autoReq   (autoReq),
    .txRdy     (txRdy)
  );

endmodule

// File: rtl/auto_pkt_req_chk.sv
module auto_pkt_req_chk #(
  parameter int CNT_W  = 16,
  parameter int SIZE_W = 11,
  parameter int FILL_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              countWe,
  input logic              autoReqWe,
  input logic              reqPktSet,
  input logic [SIZE_W-1:0] maxPkt,
  input logic              rxDone,
  input logic [SIZE_W-1:0] rxLen,
  input logic              autoSetEn,
  input logic              txRdySet,
  input logic [FILL_W-1:0] fifoCount,
  input logic              txAck,
  input logic              reqPkt,
  input logic              autoReq,
  input logic              txRdy,
  input logic [CNT_W-1:0]  remCount
);

  localparam int CMP_W = (FILL_W > SIZE_W) ? FILL_W : SIZE_W;

  logic fullPkt;
  logic autoFill;

  assign fullPkt  = (rxLen >= maxPkt);
  assign autoFill = autoSetEn && (maxPkt != '0) &&
                    (CMP_W'(fifoCount) >= CMP_W'(maxPkt));

  assert_rearm_R1: assert property (@(posedge clk) disable iff (!rstN)
    rxDone && autoReq && fullPkt && (remCount != CNT_W'(1)) |=> reqPkt);

  assert_no_rearm_R1: assert property (@(posedge clk) disable iff (!rstN)
    rxDone && !autoReq && !reqPktSet |=> !reqPkt);

  assert_count_dec_R2: assert property (@(posedge clk) disable iff (!rstN)
    rxDone && fullPkt && (remCount != '0) && !countWe
      |=> remCount == $past(remCount) - CNT_W'(1));

  assert_last_pkt_R2: assert property (@(posedge clk) disable iff (!rstN)
    rxDone && fullPkt && (remCount == CNT_W'(1)) && !reqPktSet
      |=> !autoReq && !reqPkt);

  assert_unknown_len_R3: assert property (@(posedge clk) disable iff (!rstN)
    rxDone && autoReq && fullPkt && (remCount == '0) |=> autoReq && reqPkt);

  assert_short_end_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxDone && (rxLen < maxPkt) && !countWe |=> !autoReq && (remCount == '0));

  assert_auto_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    autoFill |=> txRdy);

  assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !txRdy && !txRdySet && !autoFill |=> !txRdy);

  assert_tx_ack_R7: assert property (@(posedge clk) disable iff (!rstN)
    txAck && !txRdySet && !autoFill |=> !txRdy);

  assert_reset_R9: assert property (@(posedge clk)
    !rstN |=> !reqPkt && !autoReq && !txRdy && (remCount == '0));

endmodule

bind auto_pkt_req auto_pkt_req_chk #(
  .CNT_W (CNT_W),
  .SIZE_W(SIZE_W),
  .FILL_W(FILL_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .countWe  (countWe),
  .autoReqWe(autoReqWe),
  .reqPktSet(reqPktSet),
  .maxPkt   (maxPkt),
  .rxDone   (rxDone),
  .rxLen    (rxLen),
  .autoSetEn(autoSetEn),
  .txRdySet (txRdySet),
  .fifoCount(fifoCount),
  .txAck    (txAck),
  .reqPkt   (reqPkt),
  .autoReq  (autoReq),
  .txRdy    (txRdy),
  .remCount (remCount)
);

// File: tb/tb_auto_pkt_req.sv
module tb_auto_pkt_req;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 16;
  localparam int SIZE_W = 11;
  localparam int FILL_W = 13;

  logic              clk = 1'b0;
  logic              rstN;
  logic              countWe;
  logic [CNT_W-1:0]  countIn;
  logic              autoReqWe;
  logic              autoReqVal;
  logic              reqPktSet;
  logic [SIZE_W-1:0] maxPkt;
  logic              rxDone;
  logic [SIZE_W-1:0] rxLen;
  logic              autoSetEn;
  logic              txRdySet;
  logic [FILL_W-1:0] fifoCount;
  logic              txAck;
  logic              reqPkt;
  logic              autoReq;
  logic              txRdy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  auto_pkt_req #(
    .CNT_W (CNT_W),
    .SIZE_W(SIZE_W),
    .FILL_W(FILL_W)
  ) dut (
    .clk       (clk),
    .rstN      (rstN),
    .countWe   (countWe),
    .countIn   (countIn),
    .autoReqWe (autoReqWe),
    .autoReqVal(autoReqVal),
    .reqPktSet (reqPktSet),
    .maxPkt    (maxPkt),
    .rxDone    (rxDone),
    .rxLen     (rxLen),
    .autoSetEn (autoSetEn),
    .txRdySet  (txRdySet),
    .fifoCount (fifoCount),
    .txAck     (txAck),
    .reqPkt    (reqPkt),
    .autoReq   (autoReq),
    .txRdy     (txRdy)
  );

  typedef struct packed {
    logic        cntWe;
    logic [15:0] cnt;
    logic        arWe;
    logic        arVal;
    logic        reqSet;
    logic        rx;
    logic [10:0] len;
    logic        ase;
    logic        txSet;
    logic [12:0] fill;
    logic        ack;
    logic        eReq;
    logic        eAuto;
    logic        eTx;
    logic [3:0]  tag;
  } vec_t;

  localparam int NVEC = 32;

  // all rows assume maxPkt = 64
  localparam vec_t VEC [NVEC] = '{
    '{1, 3, 1, 1, 1, 0,  0, 0, 0,   0, 0, 1, 1, 0, 8}, // R8 load 3, arm
    '{0, 0, 0, 0, 0, 1, 64, 0, 0,   0, 0, 1, 1, 0, 1}, // R1 re-arm
    '{0, 0, 0, 0, 0, 1, 64, 0, 0,   0, 0, 1, 1, 0, 2}, // R2 count 1 left
    '{0, 0, 0, 0, 0, 1, 64, 0, 0,   0, 0, 0, 0, 0, 2}, // R2 reaches zero
    '{0, 0, 0, 0, 0, 0,  0, 0, 0,   0, 0, 0, 0, 0, 2}, // R2 stays off
    '{1, 0, 1, 1, 1, 0,  0, 0, 0,   0, 0, 1, 1, 0, 8}, // R8 unknown length
    '{0, 0, 0, 0, 0, 1, 64, 0, 0,   0, 0, 1, 1, 0, 3}, // R3
    '{0, 0, 0, 0, 0, 1, 64, 0, 0,   0, 0, 1, 1, 0, 3}, // R3
    '{0, 0, 0, 0, 0, 1, 10, 0, 0,   0, 0, 0, 0, 0, 4}, // R4 short ends
    '{1, 5, 1, 1, 1, 0,  0, 0, 0,   0, 0, 1, 1, 0, 8}, // R8 load 5
    '{0, 0, 0, 0, 0, 1, 63, 0, 0,   0, 0, 0, 0, 0, 4}, // R4 maxPkt-1 short
    '{0, 0, 1, 1, 1, 0,  0, 0, 0,   0, 0, 1, 1, 0, 8}, // R8 re-arm, no load
    '{0, 0, 0, 0, 0, 1, 64, 0, 0,   0, 0, 1, 1, 0, 4}, // R4 count was zeroed
    '{0, 0, 0, 0, 0, 1, 64, 0, 0,   0, 0, 1, 1, 0, 4}, // R4
    '{0, 0, 0, 0, 0, 1, 64, 0, 0,   0, 0, 1, 1, 0, 4}, // R4
    '{0, 0, 0, 0, 0, 1, 64, 0, 0,   0, 0, 1, 1, 0, 4}, // R4 fourth full pkt
    '{0, 0, 0, 0, 0, 1,  0, 0, 0,   0, 0, 0, 0, 0, 4}, // R4 zero-length
    '{0, 0, 0, 0, 1, 0,  0, 0, 0,   0, 0, 1, 0, 0, 8}, // R8 manual request
    '{0, 0, 0, 0, 0, 1, 64, 0, 0,   0, 0, 0, 0, 0, 1}, // R1 no auto, no re-arm
    '{0, 0, 0, 0, 0, 0,  0, 1, 0,  63, 0, 0, 0, 0, 5}, // R5 not full yet
    '{0, 0, 0, 0, 0, 0,  0, 1, 0,  64, 0, 0, 0, 1, 5}, // R5 full
    '{0, 0, 0, 0, 0, 0,  0, 1, 0,   0, 1, 0, 0, 0, 7}, // R7 ack clears
    '{0, 0, 0, 0, 0, 0,  0, 0, 0,  64, 0, 0, 0, 0, 6}, // R6 no auto-set
    '{0, 0, 0, 0, 0, 0,  0, 0, 1,  64, 0, 0, 0, 1, 6}, // R6 explicit set
    '{0, 0, 0, 0, 0, 0,  0, 0, 0,   0, 1, 0, 0, 0, 7}, // R7
    '{0, 0, 0, 0, 0, 0,  0, 1, 0, 100, 0, 0, 0, 1, 5}, // R5 above max
    '{0, 0, 0, 0, 0, 0,  0, 0, 1,   0, 1, 0, 0, 1, 7}, // R7 set beats ack
    '{0, 0, 0, 0, 0, 0,  0, 0, 0,   0, 1, 0, 0, 0, 7}, // R7
    '{0, 0, 1, 1, 0, 0,  0, 0, 0,   0, 0, 0, 1, 0, 8}, // R8 enable write
    '{0, 0, 1, 0, 0, 0,  0, 0, 0,   0, 0, 0, 0, 0, 8}, // R8 disable write
    '{1, 1, 1, 1, 1, 0,  0, 0, 0,   0, 0, 1, 1, 0, 8}, // R8 load 1
    '{0, 0, 1, 1, 0, 1, 64, 0, 0,   0, 0, 0, 0, 0, 8}  // R8 end beats write
  };

  task automatic check(input bit ok, input string what, input logic [2:0] act,
                       input logic [2:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: {reqPkt,autoReq,txRdy} actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic checkOuts(input logic [2:0] exp, input string what);
    logic [2:0] act;
    act = {reqPkt, autoReq, txRdy};
    check(act === exp, what, act, exp);
  endtask

  task automatic idleInputs();
    countWe = 0; countIn = '0; autoReqWe = 0; autoReqVal = 0; reqPktSet = 0;
    rxDone = 0; rxLen = '0; autoSetEn = 0; txRdySet = 0; fifoCount = '0; txAck = 0;
  endtask

  task automatic applyVec(input vec_t v);
    @(negedge clk);
    countWe = v.cntWe; countIn = v.cnt; autoReqWe = v.arWe; autoReqVal = v.arVal;
    reqPktSet = v.reqSet; rxDone = v.rx; rxLen = v.len; autoSetEn = v.ase;
    txRdySet = v.txSet; fifoCount = v.fill; txAck = v.ack;
    @(posedge clk);
    #1;
  endtask

  function automatic vec_t mk(input bit cw, input int c, input bit aw, input bit av,
                              input bit rs, input bit rx, input int len, input bit ase,
                              input bit ts, input int fill, input bit ack);
    vec_t v;
    v = '0;
    v.cntWe = cw; v.cnt = 16'(c); v.arWe = aw; v.arVal = av; v.reqSet = rs;
    v.rx = rx; v.len = 11'(len); v.ase = ase; v.txSet = ts; v.fill = 13'(fill);
    v.ack = ack;
    return v;
  endfunction

  initial begin
    rstN = 1'b0;
    maxPkt = 11'd64;
    idleInputs();
    repeat (2) @(posedge clk);
    #1;
    checkOuts(3'b000, "R9 reset state");
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      applyVec(VEC[i]);
      checkOuts({VEC[i].eReq, VEC[i].eAuto, VEC[i].eTx},
                $sformatf("R%0d vector %0d", VEC[i].tag, i));
    end

    // R5 corner: maxPkt of zero never fires auto-set
    maxPkt = 11'd0;
    applyVec(mk(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0));
    checkOuts(3'b000, "R5 maxPkt zero, empty fifo");
    applyVec(mk(0, 0, 0, 0, 0, 0, 0, 1, 0, 5, 0));
    checkOuts(3'b000, "R5 maxPkt zero, data in fifo");

    // R4/R3 at a larger maxPkt boundary
    @(negedge clk);
    maxPkt = 11'd512;
    applyVec(mk(1, 0, 1, 1, 1, 0, 0, 0, 0, 0, 0));
    checkOuts(3'b110, "R8 arm at maxPkt 512");
    applyVec(mk(0, 0, 0, 0, 0, 1, 512, 0, 0, 0, 0));
    checkOuts(3'b110, "R3 length equal to maxPkt is full");
    applyVec(mk(0, 0, 0, 0, 0, 1, 511, 0, 0, 0, 0));
    checkOuts(3'b000, "R4 length 511 is short");

    // R2 single-packet transfer
    applyVec(mk(1, 1, 1, 1, 1, 0, 0, 0, 0, 0, 0));
    checkOuts(3'b110, "R2 arm with count 1");
    applyVec(mk(0, 0, 0, 0, 0, 1, 600, 0, 0, 0, 0));
    checkOuts(3'b000, "R2 single packet ends transfer");

    // R9 reset in the middle of activity
    applyVec(mk(1, 7, 1, 1, 1, 0, 0, 0, 1, 0, 0));
    checkOuts(3'b111, "R9 all flags set before reset");
    @(negedge clk);
    idleInputs();
    rstN = 1'b0;
    #1;
    checkOuts(3'b000, "R9 flags cleared by reset");
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    applyVec(mk(0, 0, 1, 1, 1, 0, 0, 0, 0, 0, 0));
    applyVec(mk(0, 0, 0, 0, 0, 1, 600, 0, 0, 0, 0));
    checkOuts(3'b110, "R9 count zero after reset keeps auto-request");

    idleInputs();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
    $finish;
  end

endmodule